// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Used-Bit Replacement

The block is a small, fully associative translation buffer. Each slot holds one mapping:
- a virtual page tag
- a partition number
- a context number
- a real-address flag
- a page-size code
- a physical page address
- a privileged flag

A lookup compares the request against every valid slot in the same cycle. It returns hit or miss, the slot index, the privileged flag and the physical address. The physical address is built from the slot's page base and the request's page offset.

Mappings enter through an insert port. The port either names the target slot or lets the replacement logic choose one. A demap port removes every slot that matches a given key.

Replacement relies on one used bit per slot and a count of used bits. A lookup that has its enable set and hits a slot whose used bit is clear sets that bit. When that hit would leave every slot marked used, all used bits clear instead, except the one just hit. An insert without a target slot takes the lowest slot that is empty or not marked used. Page walks, entry-format decoding and fault recording are handled by neighbouring logic.

Top module: `tlb_assoc`

## Requirements
- R1: After reset no slot is valid, and every lookup misses.
- R2: An insert with `ins_use_idx` high writes slot `ins_idx`. The slot becomes valid with its used bit clear. `ins_idx` must be below ENTRIES.
- R3: An insert with `ins_use_idx` low writes the lowest-numbered slot that is invalid or has its used bit clear. Only if no such slot exists does it write slot ENTRIES-1. Because of R8, such a slot always exists.
- R4: A slot hits when all of these hold: it is valid; its virtual address equals the request above the slot's page offset; and its partition, context and real flag are equal to the request's. When several slots hit, the lowest index is reported.
- R5: On a miss, `lk_miss` is 1 and `lk_hit` is 0, and `lk_idx`, `lk_pa` and `lk_priv` are all 0.
- R6: Size code k means a page of 2^(12+3k) bytes, so code 0 is 4 KiB and code 1 is 32 KiB. `lk_pa` takes the slot's physical address with the offset bits cleared, ORed with the request address bits below the page size.
- R7: A lookup with `lk_en` high that hits a slot whose used bit is clear sets that bit. The internal count always equals the number of set used bits.
- R8: If the hit in R7 would make every slot used, all used bits clear except the hit slot's, and the count becomes 1.
- R9: `dm_en` invalidates every slot that matches the demap key under the R4 rule and clears those slots' used bits. Other slots are unchanged.
- R10: At most one state change happens per cycle. Demap beats insert, and insert beats the used-bit update. An action that loses is discarded.
- R11: Lookup outputs are combinational, so they appear in the same cycle. Used bits change only on a hit with `lk_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_en | input | 1 | Insert request |
| ins_use_idx | input | 1 | 1: use ins_idx; 0: replacement picks the slot |
| ins_idx | input | IW | Explicit target slot |
| ins_va | input | VA_W | Virtual address of the new mapping |
| ins_pid | input | PID_W | Partition number |
| ins_cid | input | CID_W | Context number |
| ins_rmode | input | 1 | Real-address flag |
| ins_size | input | SZ_W | Page-size code |
| ins_pa | input | PA_W | Physical page address |
| ins_priv | input | 1 | Privileged-page flag |
| lk_en | input | 1 | Lookup counts for replacement |
| lk_va | input | VA_W | Lookup virtual address |
| lk_pid | input | PID_W | Lookup partition |
| lk_cid | input | CID_W | Lookup context |
| lk_rmode | input | 1 | Lookup real flag |
| lk_hit | output | 1 | Lookup hit |
| lk_miss | output | 1 | Lookup miss |
| lk_idx | output | IW | Hit slot index |
| lk_pa | output | PA_W | Composed physical address |
| lk_priv | output | 1 | Privileged flag of hit slot |
| dm_en | input | 1 | Demap request |
| dm_va | input | VA_W | Demap virtual address |
| dm_pid | input | PID_W | Demap partition |
| dm_cid | input | CID_W | Demap context |
| dm_rmode | input | 1 | Demap real flag |

## Verification
The assertions take two things for granted. First, an explicit insert index lies inside the table. Second, the enables and keys hold known values once reset has been released. The bench meets both by driving only indices 0 to 3 into a four-slot instance and by driving every input from reset onward. The assertions make no assumption that keys are unique. The stimulus deliberately places two copies of one key to exercise lowest-index priority and multi-slot demap.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int VA_W       = 32;
  parameter int PA_W       = 32;
  parameter int PID_W      = 8;
  parameter int CID_W      = 13;
  parameter int SZ_W       = 2;
  parameter int MIN_SHIFT  = 12;
  parameter int SHIFT_STEP = 3;

  typedef struct packed {
    logic [VA_W-1:0]  va;
    logic [PID_W-1:0] pid;
    logic [CID_W-1:0] cid;
    logic             rmode;
    logic [SZ_W-1:0]  size;
    logic [PA_W-1:0]  pa;
    logic             priv;
  } tlb_ent_t;

  // Offset bits inside a page of the given size code.
  function automatic logic [VA_W-1:0] off_mask(input logic [SZ_W-1:0] code);
    int sh;
    sh = MIN_SHIFT + SHIFT_STEP * int'(code);
    return (VA_W'(1) << sh) - VA_W'(1);
  endfunction

  function automatic logic key_match(input tlb_ent_t e,
                                     input logic [VA_W-1:0] va,
                                     input logic [PID_W-1:0] pid,
                                     input logic [CID_W-1:0] cid,
                                     input logic rmode);
    return (((e.va ^ va) & ~off_mask(e.size)) == '0) &&
           (e.pid == pid) && (e.cid == cid) && (e.rmode == rmode);
  endfunction

  function automatic logic [PA_W-1:0] join_pa(input logic [PA_W-1:0] pa,
                                              input logic [VA_W-1:0] va,
                                              input logic [SZ_W-1:0] code);
    logic [PA_W-1:0] m;
    m = PA_W'(off_mask(code));
    return (pa & ~m) | (PA_W'(va) & m);
  endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  tlb_ent_t          ents [N],
  input  logic [N-1:0]      vld,
  input  logic [VA_W-1:0]   q_va,
  input  logic [PID_W-1:0]  q_pid,
  input  logic [CID_W-1:0]  q_cid,
  input  logic              q_rmode,
  output logic [N-1:0]      hits,
  output logic              any,
  output logic [IW-1:0]     idx
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hits[g] = vld[g] && key_match(ents[g], q_va, q_pid, q_cid, q_rmode);
  end

  assign any = |hits;

  // Lowest index wins: scan downward so the last assignment is the lowest.
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vld,
  input  logic [N-1:0]  used,
  output logic [IW-1:0] idx,
  output logic          found
);
  always_comb begin
    found = 1'b0;
    idx   = IW'(N - 1);
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld[i] || !used[i]) begin
        idx   = IW'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_en,
  input  logic             ins_use_idx,
  input  logic [IW-1:0]    ins_idx,
  input  logic [VA_W-1:0]  ins_va,
  input  logic [PID_W-1:0] ins_pid,
  input  logic [CID_W-1:0] ins_cid,
  input  logic             ins_rmode,
  input  logic [SZ_W-1:0]  ins_size,
  input  logic [PA_W-1:0]  ins_pa,
  input  logic             ins_priv,
  input  logic             lk_en,
  input  logic [VA_W-1:0]  lk_va,
  input  logic [PID_W-1:0] lk_pid,
  input  logic [CID_W-1:0] lk_cid,
  input  logic             lk_rmode,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic [IW-1:0]    lk_idx,
  output logic [PA_W-1:0]  lk_pa,
  output logic             lk_priv,
  input  logic             dm_en,
  input  logic [VA_W-1:0]  dm_va,
  input  logic [PID_W-1:0] dm_pid,
  input  logic [CID_W-1:0] dm_cid,
  input  logic             dm_rmode
);
  localparam int CW = $clog2(ENTRIES + 1);

  tlb_ent_t            ents [ENTRIES];
  logic [ENTRIES-1:0]  vld, used;
  logic [CW-1:0]       cnt;

  logic [ENTRIES-1:0]  lk_hits, dm_hits;
  logic                lk_any, dm_any;
  logic [IW-1:0]       lk_sel, dm_sel, vic_idx, wr_idx;
  logic                vic_found;
  tlb_ent_t            sel_ent, new_ent;

  tlb_match #(.N(ENTRIES), .IW(IW)) u_lk (
    .ents(ents), .vld(vld), .q_va(lk_va), .q_pid(lk_pid), .q_cid(lk_cid),
    .q_rmode(lk_rmode), .hits(lk_hits), .any(lk_any), .idx(lk_sel));

  tlb_match #(.N(ENTRIES), .IW(IW)) u_dm (
    .ents(ents), .vld(vld), .q_va(dm_va), .q_pid(dm_pid), .q_cid(dm_cid),
    .q_rmode(dm_rmode), .hits(dm_hits), .any(dm_any), .idx(dm_sel));

  tlb_victim #(.N(ENTRIES), .IW(IW)) u_vic (
    .vld(vld), .used(used), .idx(vic_idx), .found(vic_found));

  // Named events, one per state-changing action (R10 priority order).
  logic ev_demap, ev_ins, ev_use, ev_sat;
  logic [CW-1:0] dm_used_cnt;
  assign ev_demap    = dm_en;
  assign ev_ins      = ins_en && !dm_en;
  assign ev_use      = lk_en && lk_any && !dm_en && !ins_en && !used[lk_sel];
  assign ev_sat      = ev_use && (cnt == CW'(ENTRIES - 1));
  assign wr_idx      = ins_use_idx ? ins_idx : vic_idx;
  assign dm_used_cnt = CW'($countones(dm_hits & used));

  assign new_ent = '{va: ins_va, pid: ins_pid, cid: ins_cid, rmode: ins_rmode,
                     size: ins_size, pa: ins_pa, priv: ins_priv};

  assign sel_ent = ents[lk_sel];
  assign lk_hit  = lk_any;
  assign lk_miss = !lk_any;
  assign lk_idx  = lk_any ? lk_sel : '0;
  assign lk_pa   = lk_any ? join_pa(sel_ent.pa, lk_va, sel_ent.size) : '0;
  assign lk_priv = lk_any && sel_ent.priv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= '0;
      used <= '0;
      cnt  <= '0;
      for (int i = 0; i < ENTRIES; i++) ents[i] <= '0;
    end else if (ev_demap) begin
      vld  <= vld & ~dm_hits;
      used <= used & ~dm_hits;
      cnt  <= cnt - dm_used_cnt;
    end else if (ev_ins) begin
      ents[wr_idx] <= new_ent;
      vld[wr_idx]  <= 1'b1;
      used[wr_idx] <= 1'b0;
      if (used[wr_idx]) cnt <= cnt - CW'(1);
    end else if (ev_use) begin
      if (ev_sat) begin
        used <= ENTRIES'(1) << lk_sel;
        cnt  <= CW'(1);
      end else begin
        used[lk_sel] <= 1'b1;
        cnt          <= cnt + CW'(1);
      end
    end
  end

  // R2: explicit index must address an existing slot
  a_r2_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_en && ins_use_idx) |-> (int'(ins_idx) < ENTRIES));
  // R3: replacement always finds an unused or empty slot
  a_r3_slot_available: assert property (@(posedge clk) disable iff (!rst_n)
    vic_found);
  // R4: a reported hit points at a valid slot
  a_r4_hit_valid: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> vld[lk_idx]);
  // R5: miss outputs are zero
  a_r5_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> (lk_pa == '0 && !lk_priv && lk_idx == '0 && !lk_hit));
  // R7: counter tracks the used bits
  a_r7_count_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) == $countones(used));
  // R8: saturation leaves only the hit slot marked
  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sat |=> (cnt == CW'(1) && used == (ENTRIES'(1) << $past(lk_sel))));
  // R9: demapped slots are gone, used bits only on valid slots
  a_r9_demap_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ev_demap |=> ((vld & $past(dm_hits)) == '0));
  a_r9_used_only_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (used & ~vld) == '0);
  // R10: a written slot is valid and unmarked
  a_r10_insert_fresh: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ins |=> (vld[$past(wr_idx)] && !used[$past(wr_idx)]));
  // R11: no used bit rises without a lookup enable
  a_r11_no_use_without_en: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_en |=> ((used & ~$past(used)) == '0));
endmodule

// File: tb/sim_tlb_assoc.sv
module sim_tlb_assoc;
  import tlb_pkg::*;

  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic ins_en = 0, ins_use_idx = 0, ins_rmode = 0, ins_priv = 0;
  logic [1:0] ins_idx = '0;
  logic [VA_W-1:0] ins_va = '0;
  logic [PID_W-1:0] ins_pid = '0;
  logic [CID_W-1:0] ins_cid = '0;
  logic [SZ_W-1:0] ins_size = '0;
  logic [PA_W-1:0] ins_pa = '0;
  logic lk_en = 0, lk_rmode = 0;
  logic [VA_W-1:0] lk_va = '0;
  logic [PID_W-1:0] lk_pid = '0;
  logic [CID_W-1:0] lk_cid = '0;
  logic lk_hit, lk_miss, lk_priv;
  logic [1:0] lk_idx;
  logic [PA_W-1:0] lk_pa;
  logic dm_en = 0, dm_rmode = 0;
  logic [VA_W-1:0] dm_va = '0;
  logic [PID_W-1:0] dm_pid = '0;
  logic [CID_W-1:0] dm_cid = '0;

  tlb_assoc #(.ENTRIES(N)) u0 (
    .clk(clk), .rst_n(rst_n),
    .ins_en(ins_en), .ins_use_idx(ins_use_idx), .ins_idx(ins_idx), .ins_va(ins_va),
    .ins_pid(ins_pid), .ins_cid(ins_cid), .ins_rmode(ins_rmode), .ins_size(ins_size),
    .ins_pa(ins_pa), .ins_priv(ins_priv),
    .lk_en(lk_en), .lk_va(lk_va), .lk_pid(lk_pid), .lk_cid(lk_cid), .lk_rmode(lk_rmode),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_idx(lk_idx), .lk_pa(lk_pa), .lk_priv(lk_priv),
    .dm_en(dm_en), .dm_va(dm_va), .dm_pid(dm_pid), .dm_cid(dm_cid), .dm_rmode(dm_rmode));

  typedef struct packed {
    logic        hit;
    logic [1:0]  idx;
    logic [31:0] pa;
    logic        priv;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int checks = 0, failures = 0;
  bit done = 0;

  // Restated composition: keep page bits of the frame, offset bits of the request.
  function automatic logic [31:0] epa(logic [31:0] pa, logic [31:0] va, int code);
    int sh;
    logic [31:0] page;
    sh = 12 + 3 * code;
    page = (pa >> sh) << sh;
    return page | (va - ((va >> sh) << sh));
  endfunction

  task automatic tick();
    @(negedge clk);
    ins_en = 0; dm_en = 0; lk_en = 0;
  endtask

  task automatic set_ins(logic use_idx, logic [1:0] idx, logic [31:0] va, logic rm,
                         logic [1:0] code, logic [31:0] pa, logic priv);
    ins_en = 1; ins_use_idx = use_idx; ins_idx = idx; ins_va = va;
    ins_pid = 8'd1; ins_cid = 13'd5; ins_rmode = rm; ins_size = code;
    ins_pa = pa; ins_priv = priv;
  endtask

  task automatic set_dm(logic [31:0] va, logic rm);
    dm_en = 1; dm_va = va; dm_pid = 8'd1; dm_cid = 13'd5; dm_rmode = rm;
  endtask

  // Driver: apply a lookup and push the expected result for the monitor.
  task automatic set_look(logic en, logic [31:0] va, int pid, int cid, logic rm,
                          logic ehit, logic [1:0] eidx, logic [31:0] ep, logic epriv,
                          string tag);
    exp_t e;
    lk_en = en; lk_va = va; lk_pid = PID_W'(pid); lk_cid = CID_W'(cid); lk_rmode = rm;
    e.hit = ehit; e.idx = ehit ? eidx : 2'd0; e.pa = ehit ? ep : 32'd0;
    e.priv = ehit && epriv;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // Monitor: compare between edges.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (exp_q.size() > 0) begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (lk_hit !== e.hit || lk_miss !== !e.hit || lk_idx !== e.idx ||
            lk_pa !== e.pa || lk_priv !== e.priv) begin
          failures++;
          $display("FAIL %s: got hit=%0b miss=%0b idx=%0d pa=%h priv=%0b, exp hit=%0b idx=%0d pa=%h priv=%0b",
                   t, lk_hit, lk_miss, lk_idx, lk_pa, lk_priv, e.hit, e.idx, e.pa, e.priv);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick(); set_look(0, 32'h0001_2345, 1, 5, 0, 0, 0, 0, 0, "R1 empty after reset");
    tick(); set_look(0, 32'h0000_0000, 0, 0, 0, 0, 0, 0, 0, "R5 miss zero outputs");
    // A, automatic into empty table -> slot 0
    tick(); set_ins(0, 0, 32'h0001_2000, 0, 0, 32'h8000_0000, 0);
    tick(); set_look(1, 32'h0001_2345, 1, 5, 0, 1, 0, epa(32'h8000_0000, 32'h0001_2345, 0), 0, "R3 first slot, R6 4K compose");
    // B: slot 0 used, slot 1 empty -> slot 1
    tick(); set_ins(0, 0, 32'h0003_4000, 0, 0, 32'h9000_0000, 0);
    tick(); set_look(0, 32'h0003_4ABC, 1, 5, 0, 1, 1, 32'h9000_0ABC, 0, "R3 skip used slot");
    // C, 32K page: B never marked (lk_en low) so slot 1 is reused
    tick(); set_ins(0, 0, 32'h0010_0000, 0, 1, 32'h A000_7FFF, 0);
    tick(); set_look(1, 32'h0010_5678, 1, 5, 0, 1, 1, epa(32'hA000_7FFF, 32'h0010_5678, 1), 0, "R6 32K compose, R11 reuse unmarked");
    tick(); set_look(0, 32'h0003_4ABC, 1, 5, 0, 0, 0, 0, 0, "R11 disabled lookup left slot replaceable");
    // D explicit slot 3, real, privileged
    tick(); set_ins(1, 3, 32'h0020_0000, 1, 0, 32'hB000_1000, 1);
    tick(); set_look(0, 32'h0020_0010, 1, 5, 0, 0, 0, 0, 0, "R4 real flag mismatch");
    tick(); set_look(1, 32'h0020_0010, 1, 5, 1, 1, 3, 32'hB000_1010, 1, "R2 explicit slot 3");
    tick(); set_look(0, 32'h0001_2345, 2, 5, 0, 0, 0, 0, 0, "R4 partition mismatch");
    tick(); set_look(0, 32'h0001_2345, 1, 6, 0, 0, 0, 0, 0, "R4 context mismatch");
    tick(); set_look(0, 32'h0001_3345, 1, 5, 0, 0, 0, 0, 0, "R4 page mismatch");
    // E into slot 2, then its hit saturates
    tick(); set_ins(0, 0, 32'h0030_0000, 0, 0, 32'hC000_0000, 0);
    tick(); set_look(1, 32'h0030_0004, 1, 5, 0, 1, 2, 32'hC000_0004, 0, "R3 empty slot 2, R7 mark");
    // F: after saturation only slot 2 is marked -> slot 0
    tick(); set_ins(0, 0, 32'h0040_0000, 0, 0, 32'hD000_0000, 0);
    tick(); set_look(0, 32'h0040_0008, 1, 5, 0, 1, 0, 32'hD000_0008, 0, "R8 saturation freed slot 0");
    tick(); set_look(0, 32'h0001_2345, 1, 5, 0, 0, 0, 0, 0, "R8 old slot 0 mapping replaced");
    tick(); set_look(0, 32'h0020_0000, 1, 5, 1, 1, 3, 32'hB000_1000, 1, "R8 slot 3 kept");
    // duplicate of F key in slot 1
    tick(); set_ins(1, 1, 32'h0040_0000, 0, 0, 32'hE000_0000, 0);
    tick(); set_look(0, 32'h0040_0008, 1, 5, 0, 1, 0, 32'hD000_0008, 0, "R4 lowest index wins");
    tick(); set_dm(32'h0040_0123, 0);
    tick(); set_look(0, 32'h0040_0008, 1, 5, 0, 0, 0, 0, 0, "R9 both copies removed");
    tick(); set_look(0, 32'h0030_0000, 1, 5, 0, 1, 2, 32'hC000_0000, 0, "R9 other slot kept");
    // demap D and insert H in the same cycle: demap wins
    tick(); set_dm(32'h0020_0000, 1); set_ins(0, 0, 32'h0050_0000, 0, 0, 32'hF000_0000, 0);
    tick(); set_look(0, 32'h0020_0000, 1, 5, 1, 0, 0, 0, 0, "R10 demap applied");
    tick(); set_look(0, 32'h0050_0000, 1, 5, 0, 0, 0, 0, 0, "R10 insert dropped under demap");
    tick(); set_ins(0, 0, 32'h0050_0000, 0, 0, 32'hF000_0000, 0);
    tick(); set_look(0, 32'h0050_0040, 1, 5, 0, 1, 0, 32'hF000_0040, 0, "R3 H into slot 0");
    // insert I with an enabled lookup of H: insert wins, H stays unmarked
    tick(); set_ins(1, 3, 32'h0060_0000, 0, 0, 32'h1234_0000, 0);
            set_look(1, 32'h0050_0040, 1, 5, 0, 1, 0, 32'hF000_0040, 0, "R11 same-cycle lookup output");
    tick(); set_ins(0, 0, 32'h0070_0000, 0, 0, 32'h5555_0000, 0);
    tick(); set_look(0, 32'h0070_0010, 1, 5, 0, 1, 0, 32'h5555_0010, 0, "R10 used update dropped under insert");
    tick(); set_look(0, 32'h0060_0010, 1, 5, 0, 1, 3, 32'h1234_0010, 0, "R2 explicit slot 3 again");
    tick();
    tick();
    #3;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule